// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits passively on the control side of a single-data-rate mobile SDRAM bus. On every rising clock edge it samples the clock-enable, chip-select, row-strobe, column-strobe, write-enable, bank-address and address pins. It turns that sample into one named command, which is presented on `cmd_o` one clock later.

Alongside the decode it keeps a model of each bank: whether a row is open and which row that is. The model follows activates, precharges and accesses that close their bank automatically. Protocol slips that it can spot from the command stream alone appear as one-cycle error pulses. It also keeps copies of the standard and extended mode registers as they are loaded.

The block is meant for bus monitors, controller self-checks and debug capture. It does not model data timing, the data mask or the refresh row counter.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: With `cs_n_i` high, `cmd_o` shows INHIBIT (code 0) whatever the other pins are, and an automatic close already scheduled still takes place.
- R2: With `cs_n_i` low, `cmd_o` shows the command one clock after sampling, keyed on {ras,cas,we}. The codes are: 111 NOP=1, 011 ACTIVE=2, 101 READ=3, 100 WRITE=4, 110 BURST-STOP=5 with `cke_i` high or DEEP-POWER-DOWN=6 with `cke_i` low, 010 PRECHARGE=7, 001 AUTO-REFRESH=8 with `cke_i` high or SELF-REFRESH=9 with `cke_i` low, 000 MODE-LOAD=10.
- R3: ACTIVE to a closed bank sets that bank's bit in `bank_open_o` and stores `addr_i` in its `open_row_o` slice (bank n at bits n*13 upward). ACTIVE to an open bank pulses `err_reopen_o` and leaves the stored row unchanged.
- R4: READ or WRITE to a closed bank pulses `err_closed_o`.
- R5: READ or WRITE to an open bank with `addr_i[10]` high leaves the bank open after the command's edge and closes it at the following edge.
- R6: PRECHARGE with `addr_i[10]` low closes only the bank named by `ba_i`. With `addr_i[10]` high it closes every bank and ignores `ba_i`.
- R7: BURST-STOP pulses `err_bst_o` when the last READ or WRITE to an open bank was a READ with `addr_i[10]` high.
- R8: AUTO-REFRESH or MODE-LOAD while any bank is open pulses `err_busy_o`. A MODE-LOAD in that state writes no register.
- R9: MODE-LOAD with all banks closed writes `addr_i` to `mode_reg_o` when `ba_i`=0 and to `ext_mode_reg_o` when `ba_i`=1. Other `ba_i` values pulse `err_lmr_ba_o` and write nothing.
- R10: Reset (`rst_ni` low) closes all banks, clears stored rows and both mode registers, and sets `cmd_o` to 0 and every error output to 0.
- R11: Each error output is high for exactly the one cycle after the offending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Sampled clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 13 | Row, column or op-code; bit 10 is the auto-close / all-banks flag |
| cmd_o | output | 4 | Decoded command code |
| bank_open_o | output | 4 | One open flag per bank |
| open_row_o | output | 52 | Stored row per bank, 13 bits each |
| mode_reg_o | output | 13 | Standard mode register copy |
| ext_mode_reg_o | output | 13 | Extended mode register copy |
| err_closed_o | output | 1 | Access to a closed bank |
| err_reopen_o | output | 1 | Activate of an open bank |
| err_busy_o | output | 1 | Refresh or mode load with a bank open |
| err_bst_o | output | 1 | Burst stop after an auto-closing read |
| err_lmr_ba_o | output | 1 | Mode load to a reserved bank code |

## Verification
The assertions assume every bus pin is at a known value at each rising edge while reset is released. They also assume exactly one command is seen per edge, so an activate and a precharge never reach the same bank in one cycle. The stimulus is applied just after a falling edge and held for a full cycle, so all pins are defined at the sampling edge. The scenarios mix legal sequences with deliberate slips: double activate, access to a closed bank, refresh with a bank open, reserved mode-load bank, and burst stop after an auto-closing read. This covers both branches of every error rule.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_INH  = 4'd0,
    CMD_NOP  = 4'd1,
    CMD_ACT  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_WR   = 4'd4,
    CMD_BST  = 4'd5,
    CMD_DPD  = 4'd6,
    CMD_PRE  = 4'd7,
    CMD_REF  = 4'd8,
    CMD_SREF = 4'd9,
    CMD_LMR  = 4'd10
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_cmd_pkg::*;
(
  input  logic     cke_i,
  input  logic     cs_n_i,
  input  logic     ras_n_i,
  input  logic     cas_n_i,
  input  logic     we_n_i,
  output sdr_cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_INH;
    if (!cs_n_i) begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b110:  cmd_o = cke_i ? CMD_BST : CMD_DPD;  // cke splits one pin code
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = cke_i ? CMD_REF : CMD_SREF;
        default: cmd_o = CMD_LMR;
      endcase
    end
  end
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_cmd_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sdr_cmd_e         cmd_i,
  input  logic             sel_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             err_closed_o,
  output logic             err_reopen_o
);
  logic open_q, ap_pend_q;
  logic act, acc, pre;

  assign act = (cmd_i == CMD_ACT) && sel_i;
  assign acc = ((cmd_i == CMD_RD) || (cmd_i == CMD_WR)) && sel_i;
  assign pre = (cmd_i == CMD_PRE) && (sel_i || ap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q       <= 1'b0;
      ap_pend_q    <= 1'b0;
      row_o        <= '0;
      err_closed_o <= 1'b0;
      err_reopen_o <= 1'b0;
    end else begin
      err_closed_o <= acc && !open_q;
      err_reopen_o <= act && open_q;
      ap_pend_q    <= acc && open_q && ap_i;
      if (pre || ap_pend_q) open_q <= 1'b0;
      else if (act && !open_q) begin
        open_q <= 1'b1;
        row_o  <= row_i;
      end
    end
  end

  assign open_o = open_q;

  // R3
  act_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !open_q) |=> open_q);
  // R5
  ap_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && open_q && ap_i) |=> ##1 !open_q);
  // R6
  pre_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre |=> !open_q);
  // R11
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_closed_o && !acc) |=> !err_closed_o);
endmodule

// File: rtl/sdr_mode_regs.sv
module sdr_mode_regs
  import sdr_cmd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdr_cmd_e          cmd_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              any_open_i,
  output logic [ADDR_W-1:0] mode_o,
  output logic [ADDR_W-1:0] ext_mode_o,
  output logic              err_busy_o,
  output logic              err_ba_o
);
  logic lmr, ba_ok;

  assign lmr   = (cmd_i == CMD_LMR);
  assign ba_ok = (ba_i == BA_W'(0)) || (ba_i == BA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= '0;
      ext_mode_o <= '0;
      err_busy_o <= 1'b0;
      err_ba_o   <= 1'b0;
    end else begin
      err_busy_o <= (lmr || (cmd_i == CMD_REF)) && any_open_i;
      err_ba_o   <= lmr && !ba_ok;
      if (lmr && !any_open_i) begin
        if (ba_i == BA_W'(0))      mode_o     <= addr_i;
        else if (ba_i == BA_W'(1)) ext_mode_o <= addr_i;
      end
    end
  end

  // R8 R9
  lmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lmr && (any_open_i || !ba_ok)) |=> ($stable(mode_o) && $stable(ext_mode_o)));
  // R8
  ref_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == CMD_REF) && any_open_i) |=> err_busy_o);
endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
  import sdr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic                       cs_n_i,
  input  logic                       ras_n_i,
  input  logic                       cas_n_i,
  input  logic                       we_n_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  output logic [3:0]                 cmd_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic [ROW_W-1:0]           mode_reg_o,
  output logic [ROW_W-1:0]           ext_mode_reg_o,
  output logic                       err_closed_o,
  output logic                       err_reopen_o,
  output logic                       err_busy_o,
  output logic                       err_bst_o,
  output logic                       err_lmr_ba_o
);
  sdr_cmd_e cmd_d;
  logic [NUM_BANKS-1:0] open_q, err_cl, err_ro;
  logic rd_ap_q, acc_hit;

  sdr_cmd_decode u_dec (
    .cke_i, .cs_n_i, .ras_n_i, .cas_n_i, .we_n_i, .cmd_o(cmd_d)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdr_bank_track #(.ROW_W(ROW_W)) u_bank (
      .clk_i, .rst_ni,
      .cmd_i       (cmd_d),
      .sel_i       (ba_i == BA_W'(g)),
      .ap_i        (addr_i[AP_BIT]),
      .row_i       (addr_i),
      .open_o      (open_q[g]),
      .row_o       (open_row_o[g*ROW_W +: ROW_W]),
      .err_closed_o(err_cl[g]),
      .err_reopen_o(err_ro[g])
    );
  end

  sdr_mode_regs #(.BA_W(BA_W), .ADDR_W(ROW_W)) u_mode (
    .clk_i, .rst_ni,
    .cmd_i     (cmd_d),
    .ba_i,
    .addr_i,
    .any_open_i(|open_q),
    .mode_o    (mode_reg_o),
    .ext_mode_o(ext_mode_reg_o),
    .err_busy_o,
    .err_ba_o  (err_lmr_ba_o)
  );

  assign acc_hit = ((cmd_d == CMD_RD) || (cmd_d == CMD_WR)) && open_q[ba_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= CMD_INH;
      rd_ap_q   <= 1'b0;
      err_bst_o <= 1'b0;
    end else begin
      cmd_o     <= cmd_d;
      err_bst_o <= (cmd_d == CMD_BST) && rd_ap_q;
      // remember whether the latest live access was an auto-closing read
      if (acc_hit)                rd_ap_q <= (cmd_d == CMD_RD) && addr_i[AP_BIT];
      else if (cmd_d == CMD_BST)  rd_ap_q <= 1'b0;
    end
  end

  assign bank_open_o  = open_q;
  assign err_closed_o = |err_cl;
  assign err_reopen_o = |err_ro;

  // R1
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (cmd_o == CMD_INH));
  // R6
  pre_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !ras_n_i && cas_n_i && !we_n_i && addr_i[AP_BIT]) |=> (bank_open_o == '0));
  // R2
  dpd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && ras_n_i && cas_n_i && !we_n_i && !cke_i) |=> (cmd_o == CMD_DPD));
endmodule

// File: tb/tb_sdr_cmd_monitor.sv
module tb_sdr_cmd_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] a = '0;
  logic [3:0]  cmd;
  logic [3:0]  bopen;
  logic [51:0] rows;
  logic [12:0] mreg, emreg;
  logic e_cl, e_ro, e_busy, e_bst, e_ba;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cmd_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(a), .cmd_o(cmd),
    .bank_open_o(bopen), .open_row_o(rows), .mode_reg_o(mreg),
    .ext_mode_reg_o(emreg), .err_closed_o(e_cl), .err_reopen_o(e_ro),
    .err_busy_o(e_busy), .err_bst_o(e_bst), .err_lmr_ba_o(e_ba)
  );

  typedef struct packed {
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] a;
    logic [3:0]  cmd;
    logic [3:0]  open;
    logic [4:0]  err;  // {bst, lmr_ba, busy, reopen, closed}
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b1,1'b1,1'b1,2'd0,13'h0000,4'd1, 4'b0000,5'b00000}, // R2 nop
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,13'h0000,4'd0, 4'b0000,5'b00000}, // R1 inhibit
    '{1'b1,1'b0,1'b0,1'b1,1'b1,2'd1,13'h0ABC,4'd2, 4'b0010,5'b00000}, // R3 act b1
    '{1'b1,1'b0,1'b1,1'b0,1'b1,2'd1,13'h0005,4'd3, 4'b0010,5'b00000}, // R2 rd
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,13'h0000,4'd5, 4'b0010,5'b00000}, // R7 legal bst
    '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd2,13'h0000,4'd4, 4'b0010,5'b00001}, // R4 wr closed
    '{1'b1,1'b0,1'b0,1'b1,1'b1,2'd1,13'h0111,4'd2, 4'b0010,5'b00010}, // R3 reopen
    '{1'b1,1'b0,1'b0,1'b0,1'b1,2'd0,13'h0000,4'd8, 4'b0010,5'b00100}, // R8 ref busy
    '{1'b1,1'b0,1'b0,1'b1,1'b0,2'd1,13'h0000,4'd7, 4'b0000,5'b00000}, // R6 pre one
    '{1'b1,1'b0,1'b0,1'b0,1'b1,2'd0,13'h0000,4'd8, 4'b0000,5'b00000}, // R2 ref
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,13'h0033,4'd10,4'b0000,5'b00000}, // R9 lmr std
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'd2,13'h1FFF,4'd10,4'b0000,5'b01000}, // R9 reserved
    '{1'b1,1'b0,1'b0,1'b1,1'b1,2'd0,13'h0010,4'd2, 4'b0001,5'b00000}, // R3 act b0
    '{1'b1,1'b0,1'b0,1'b1,1'b1,2'd3,13'h0020,4'd2, 4'b1001,5'b00000}, // R3 act b3
    '{1'b1,1'b0,1'b1,1'b0,1'b1,2'd3,13'h0400,4'd3, 4'b1001,5'b00000}, // R5 rd ap
    '{1'b1,1'b0,1'b1,1'b1,1'b1,2'd0,13'h0000,4'd1, 4'b0001,5'b00000}, // R5 closed
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,13'h0000,4'd5, 4'b0001,5'b10000}, // R7 bad bst
    '{1'b1,1'b0,1'b0,1'b1,1'b0,2'd2,13'h0400,4'd7, 4'b0000,5'b00000}, // R6 pre all
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,13'h0000,4'd6, 4'b0000,5'b00000}, // R2 dpd
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,13'h0000,4'd9, 4'b0000,5'b00000}  // R2 sref
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic c, input logic r, input logic s,
                       input logic w, input logic [1:0] b, input logic [12:0] ad);
    cke = k; cs_n = c; ras_n = r; cas_n = s; we_n = w; ba = b; a = ad;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(cmd == 4'd0 && bopen == 4'd0 && rows == '0, "R10", "reset state",
          {cmd, bopen}, 64'h0);
    check(mreg == '0 && emreg == '0 && {e_bst,e_ba,e_busy,e_ro,e_cl} == '0, "R10",
          "reset regs", {mreg, emreg}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cke, VEC[i].cs_n, VEC[i].ras_n, VEC[i].cas_n, VEC[i].we_n,
            VEC[i].ba, VEC[i].a);
      check(cmd == VEC[i].cmd, "R2", $sformatf("cmd vec %0d", i), cmd, VEC[i].cmd);
      check(bopen == VEC[i].open, "R3 R6", $sformatf("open vec %0d", i), bopen, VEC[i].open);
      check({e_bst,e_ba,e_busy,e_ro,e_cl} == VEC[i].err, "R11",
            $sformatf("errors vec %0d", i), {e_bst,e_ba,e_busy,e_ro,e_cl}, VEC[i].err);
    end

    // R9 reserved code left mode register intact; R3 reopen kept row
    check(mreg == 13'h0033, "R9", "std mode", mreg, 13'h0033);
    check(emreg == 13'h0000, "R9", "ext untouched", emreg, 13'h0000);
    check(rows[13 +: 13] == 13'h0ABC, "R3", "bank1 row", rows[13 +: 13], 13'h0ABC);

    drive(1, 0, 0, 0, 0, 2'd1, 13'h0155);  // ext mode load
    check(emreg == 13'h0155, "R9", "ext mode", emreg, 13'h0155);

    drive(1, 0, 0, 1, 1, 2'd2, 13'h1F0F);  // act bank2
    check(rows[26 +: 13] == 13'h1F0F, "R3", "bank2 row", rows[26 +: 13], 13'h1F0F);
    drive(1, 0, 0, 0, 0, 2'd0, 13'h0007);  // mode load while open
    check(e_busy == 1'b1, "R8", "lmr busy pulse", e_busy, 1'b1);
    check(mreg == 13'h0033, "R8", "lmr blocked", mreg, 13'h0033);

    drive(1, 0, 1, 0, 0, 2'd2, 13'h0400);  // write, auto close
    check(bopen == 4'b0100, "R5", "open after wr ap", bopen, 4'b0100);
    check(e_busy == 1'b0, "R11", "busy cleared", e_busy, 1'b0);
    drive(1, 1, 0, 0, 0, 2'd0, 13'h0000);  // inhibit during pending close
    check(bopen == 4'b0000, "R1 R5", "closed under inhibit", bopen, 4'b0000);
    check(cmd == 4'd0, "R1", "inhibit code", cmd, 4'd0);

    drive(1, 0, 0, 1, 1, 2'd0, 13'h0001);
    drive(1, 0, 0, 1, 1, 2'd1, 13'h0002);
    drive(1, 0, 0, 1, 0, 2'd0, 13'h0000);  // precharge bank0 only
    check(bopen == 4'b0010, "R6", "single precharge", bopen, 4'b0010);
    drive(1, 0, 1, 0, 1, 2'd0, 13'h0000);  // read closed bank0
    check(e_cl == 1'b1, "R4", "rd closed", e_cl, 1'b1);

    rst_n = 1'b0;
    @(negedge clk);
    check(bopen == 4'b0000 && mreg == '0 && emreg == '0 && rows == '0, "R10",
          "mid reset", {bopen, mreg}, 64'h0);
    check(cmd == 4'd0 && e_cl == 1'b0, "R10", "mid reset cmd", cmd, 4'd0);
    summary();
  end
endmodule